// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Block

This block is the register file for one port of eight general-purpose pins. It holds three writable per-pin control bytes and one read-only byte. The first control byte chooses whether the register block owns a pin at all or leaves it to an alternate function. The second sets the pin's direction. The third holds the value driven on pins that are outputs. The read-only byte reports the pin levels after a two-flop synchronizer.

Software reaches the block over a flat 32-bit register interface made of an address, a write strobe, write data and combinational read data. Each control byte can be written in two ways:

- A plain write replaces all of its bits.
- A masked-write alias changes only the pins selected in the upper byte of the write data and leaves the rest untouched. Two agents can therefore update different pins of the same port without a read-modify-write sequence and without a lock.

Top module: `gpio_mw_port`

## Requirements
- R1: After reset, the config, direction and output bytes are all zero. Every pin is then unowned and an input, so `pad_sel`, `pad_oe` and `pad_do` are all zero.
- R2: A plain write loads bits 7:0 of the write data into the addressed byte in full. The plain addresses are config 0x000, direction 0x010 and output 0x020. Write-data bits 31:8 have no effect on a plain write.
- R3: A masked write goes to alias address 0x080 + plain address. For each pin n whose write-data bit 8+n is 1, bit n of the byte takes write-data bit n.
- R4: In a masked write, every pin whose write-data bit 8+n is 0 keeps its previous value. A mask of zero changes nothing.
- R5: Reading the input address returns the pin levels seen through a two-stage synchronizer. The plain input address is 0x030 and the alias is 0x0B0. A change on `pin_in` becomes visible after the second rising clock edge, not after the first. The result does not depend on the config or direction bytes.
- R6: Writes to the input address, plain or alias, change no register and no pad output.
- R7: `pad_sel` equals the config byte.
- R8: `pad_oe[n]` is 1 only when both config bit n and direction bit n are 1.
- R9: `pad_do[n]` equals output bit n while `pad_oe[n]` is 1, and is 0 otherwise.
- R10: A read at a plain or alias address returns the byte in bits 7:0 and zero in bits 31:8.
- R11: A read at an address not listed above returns zero, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; on aliases, mask in 15:8 and values in 7:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Asynchronous pin levels |
| pad_sel | output | 8 | 1 where the pin is owned by this block |
| pad_oe | output | 8 | Per-pin output enable |
| pad_do | output | 8 | Per-pin output value |

## Verification
The bench goes after the bits a masked write must leave alone. It uses sparse masks, a zero mask and a full mask over non-trivial old values. A design that merged using the wrong byte, or cleared unmasked bits, would corrupt neighbouring pins, and the shadow comparison after each alias write shows the damage.

The bench samples the input register after exactly one edge and again after two. A synchronizer with one stage too few or one too many therefore shows up as an early or late value. The same reads are repeated with the pins configured as outputs, to catch a design that gates the input by direction.

Writes to the read-only input address and to unmapped holes are each followed by readbacks and pad checks. Aliases are also read back with stray high write-data bits set. Both catch a decoder that aliases too loosely or leaks bits above the byte.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;

  // writable control bytes, in decode order
  localparam int unsigned NREG     = 3;
  localparam int unsigned REG_CFG  = 0;
  localparam int unsigned REG_DIR  = 1;
  localparam int unsigned REG_OUT  = 2;
  localparam int unsigned REG_PINS = 3;

  // distance between consecutive register addresses
  localparam int unsigned REG_STRIDE = 16;

  typedef enum logic [2:0] {
    RS_NONE = 3'd0,
    RS_CFG  = 3'd1,
    RS_DIR  = 3'd2,
    RS_OUT  = 3'd3,
    RS_PINS = 3'd4
  } rsel_e;

  function automatic int unsigned reg_offset(input int unsigned idx);
    return idx * REG_STRIDE;
  endfunction

endpackage

// File: rtl/gpio_mw_decode.sv
module gpio_mw_decode
  import gpio_mw_pkg::*;
#(
  parameter int unsigned AW        = 12,
  parameter int unsigned ALIAS_OFS = 12'h080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            we,
  output logic [NREG-1:0] plain_we,
  output logic [NREG-1:0] mask_we,
  output rsel_e           rd_sel
);

  localparam logic [AW-1:0] A_PINS_P = AW'(reg_offset(REG_PINS));
  localparam logic [AW-1:0] A_PINS_M = AW'(ALIAS_OFS + reg_offset(REG_PINS));

  logic [NREG-1:0] hit_plain;
  logic [NREG-1:0] hit_alias;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    localparam logic [AW-1:0] A_P = AW'(reg_offset(i));
    localparam logic [AW-1:0] A_M = AW'(ALIAS_OFS + reg_offset(i));
    assign hit_plain[i] = (addr == A_P);
    assign hit_alias[i] = (addr == A_M);
  end

  assign plain_we = hit_plain & {NREG{we}};
  assign mask_we  = hit_alias & {NREG{we}};

  logic pins_hit;
  assign pins_hit = (addr == A_PINS_P) || (addr == A_PINS_M);

  always_comb begin
    rd_sel = RS_NONE;
    if (hit_plain[REG_CFG] || hit_alias[REG_CFG]) rd_sel = RS_CFG;
    else if (hit_plain[REG_DIR] || hit_alias[REG_DIR]) rd_sel = RS_DIR;
    else if (hit_plain[REG_OUT] || hit_alias[REG_OUT]) rd_sel = RS_OUT;
    else if (pins_hit) rd_sel = RS_PINS;
  end

  // at most one register may be written by any bus access
  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({plain_we, mask_we})); // R11

  // the read-only input address never produces a write enable
  AST_PINS_NOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    (we && pins_hit) |-> ({plain_we, mask_we} == '0)); // R6

endmodule

// File: rtl/gpio_mw_reg.sv
module gpio_mw_reg #(
  parameter int unsigned W  = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          plain_we,
  input  logic          mask_we,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0]  q
);

  localparam int unsigned MSB_MASK = 2 * W - 1;

  // selected bits take the new value, the others keep the old one
  function automatic logic [W-1:0] masked_merge(input logic [W-1:0]  old_v,
                                                 input logic [DW-1:0] wd);
    logic [W-1:0] sel;
    logic [W-1:0] val;
    sel = wd[MSB_MASK:W];
    val = wd[W-1:0];
    return (old_v & ~sel) | (val & sel);
  endfunction

  logic [W-1:0] wr_mask;
  logic [W-1:0] wr_val;
  assign wr_mask = wdata[MSB_MASK:W];
  assign wr_val  = wdata[W-1:0];

  logic [W-1:0] q_nxt;
  always_comb begin
    q_nxt = q;
    if (plain_we)     q_nxt = wr_val;
    else if (mask_we) q_nxt = masked_merge(q, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q == '0)); // R1

  AST_PLAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    plain_we |=> (q == $past(wr_val))); // R2

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> ((q & $past(wr_mask)) == ($past(wr_val) & $past(wr_mask)))); // R3

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> ((q & ~$past(wr_mask)) == ($past(q) & ~$past(wr_mask)))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!plain_we && !mask_we) |=> $stable(q)); // R11

endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int unsigned CW = $clog2(STAGES + 1);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = chain[STAGES-1];

  // counts edges since reset so the latency check never looks before it
  logic [CW-1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 warm <= '0;
    else if (warm != CW'(STAGES)) warm <= warm + 1'b1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == CW'(STAGES)) |-> (q == $past(d, STAGES))); // R5

endmodule

// File: rtl/gpio_mw_port.sv
module gpio_mw_port
  import gpio_mw_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned AW          = 12,
  parameter int unsigned DW          = 32,
  parameter int unsigned ALIAS_OFS   = 12'h080,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pad_sel,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_do
);

  logic [NREG-1:0]  plain_we;
  logic [NREG-1:0]  mask_we;
  rsel_e            rd_sel;
  logic [NPINS-1:0] ctl_q [NREG];
  logic [NPINS-1:0] pins_sync;

  gpio_mw_decode #(
    .AW        (AW),
    .ALIAS_OFS (ALIAS_OFS)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .we       (bus_we),
    .plain_we (plain_we),
    .mask_we  (mask_we),
    .rd_sel   (rd_sel)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_ctl
    gpio_mw_reg #(
      .W  (NPINS),
      .DW (DW)
    ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .plain_we (plain_we[i]),
      .mask_we  (mask_we[i]),
      .wdata    (bus_wdata),
      .q        (ctl_q[i])
    );
  end

  gpio_mw_sync #(
    .W      (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  // pad drive: owned pins with direction set drive the output byte
  logic [NPINS-1:0] drive_en;
  assign drive_en = ctl_q[REG_CFG] & ctl_q[REG_DIR];
  assign pad_sel  = ctl_q[REG_CFG];
  assign pad_oe   = drive_en;
  assign pad_do   = ctl_q[REG_OUT] & drive_en;

  // read mux: byte in the low bits, zero above
  logic [NPINS-1:0] rd_byte;
  always_comb begin
    unique case (rd_sel)
      RS_CFG:  rd_byte = ctl_q[REG_CFG];
      RS_DIR:  rd_byte = ctl_q[REG_DIR];
      RS_OUT:  rd_byte = ctl_q[REG_OUT];
      RS_PINS: rd_byte = pins_sync;
      default: rd_byte = '0;
    endcase
  end
  assign bus_rdata = DW'(rd_byte);

  // a pin the block does not own is never driven
  AST_UNOWNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_do) & ~ctl_q[REG_CFG]) == '0); // R8

  // an unselected read never reports a register's content
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == RS_NONE) |-> (bus_rdata == '0)); // R11

endmodule

// File: tb/gpio_mw_port_tb.sv
`timescale 1ns/1ps
module gpio_mw_port_tb;

  localparam logic [11:0] A_CFG  = 12'h000;
  localparam logic [11:0] A_DIR  = 12'h010;
  localparam logic [11:0] A_OUT  = 12'h020;
  localparam logic [11:0] A_PINS = 12'h030;
  localparam logic [11:0] ALIAS  = 12'h080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pad_sel, pad_oe, pad_do;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;

  logic [7:0] m_cfg = '0, m_dir = '0, m_out = '0, m_pins = '0;

  always #10 clk = ~clk;

  gpio_mw_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pad_sel   (pad_sel),
    .pad_oe    (pad_oe),
    .pad_do    (pad_do)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side merge, bit by bit
  function automatic logic [7:0] apply_mask(input logic [7:0] old_v, input logic [31:0] wd);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = wd[8 + b] ? wd[b] : old_v[b];
    return r;
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    bus_read(A_CFG, d);  check({req, " cfg"}, d, {24'h0, m_cfg});
    bus_read(A_DIR, d);  check({req, " dir"}, d, {24'h0, m_dir});
    bus_read(A_OUT, d);  check({req, " out"}, d, {24'h0, m_out});
    check({req, " R7 pad_sel"}, {24'h0, pad_sel}, {24'h0, m_cfg});
    check({req, " R8 pad_oe"},  {24'h0, pad_oe},  {24'h0, m_cfg & m_dir});
    check({req, " R9 pad_do"},  {24'h0, pad_do},  {24'h0, m_cfg & m_dir & m_out});
  endtask

  task automatic t_reset;
    check_all("R1");
    check("R1 pad_oe zero", {24'h0, pad_oe}, 32'h0);
  endtask

  task automatic t_plain;
    bus_write(A_CFG, 32'hDEAD_F0C3); m_cfg = 8'hC3;
    bus_write(A_DIR, 32'h0000_FF5A); m_dir = 8'h5A;
    bus_write(A_OUT, 32'h1234_5678); m_out = 8'h78;
    check_all("R2 plain");
    bus_write(A_OUT, 32'hFFFF_FF00); m_out = 8'h00;
    check_all("R2 plain clear");
  endtask

  task automatic t_masked;
    bus_write(ALIAS + A_OUT, 32'h0000_81FF); m_out = apply_mask(m_out, 32'h0000_81FF);
    check_all("R3 alias set");
    bus_write(ALIAS + A_CFG, 32'h0000_3C00); m_cfg = apply_mask(m_cfg, 32'h0000_3C00);
    check_all("R3 alias clear");
    bus_write(ALIAS + A_DIR, 32'hFFFF_FFA5); m_dir = apply_mask(m_dir, 32'hFFFF_FFA5);
    check_all("R3 alias full");
  endtask

  task automatic t_mask_zero;
    bus_write(ALIAS + A_CFG, 32'h0000_00FF);
    bus_write(ALIAS + A_DIR, 32'hFFFF_00FF);
    bus_write(ALIAS + A_OUT, 32'h0000_0055);
    check_all("R4 zero mask");
    bus_write(ALIAS + A_OUT, 32'h0000_1010); m_out = apply_mask(m_out, 32'h0000_1010);
    check_all("R4 single pin");
  endtask

  task automatic t_input_sync(input logic [7:0] v);
    logic [31:0] d;
    @(negedge clk);
    bus_addr = A_PINS;
    pin_in = v;
    @(posedge clk); #2;
    check("R5 after one edge", bus_rdata, {24'h0, m_pins});
    @(posedge clk); #2;
    check("R5 after two edges", bus_rdata, {24'h0, v});
    m_pins = v;
    bus_read(ALIAS + A_PINS, d);
    check("R5 alias read", d, {24'h0, v});
  endtask

  task automatic t_input_any_dir;
    bus_write(A_CFG, 32'h0000_00FF); m_cfg = 8'hFF;
    bus_write(A_DIR, 32'h0000_00FF); m_dir = 8'hFF;
    t_input_sync(8'h3C);
    bus_write(A_CFG, 32'h0000_0000); m_cfg = 8'h00;
    t_input_sync(8'hC1);
    check_all("R5 dir mix");
  endtask

  task automatic t_ro_writes;
    logic [31:0] d;
    bus_write(A_PINS, 32'h0000_00FF);
    bus_write(ALIAS + A_PINS, 32'h0000_FF00);
    bus_read(A_PINS, d);
    check("R6 pins unchanged", d, {24'h0, m_pins});
    check_all("R6");
  endtask

  task automatic t_alias_read;
    logic [31:0] d;
    bus_write(A_CFG, 32'h0000_00A6); m_cfg = 8'hA6;
    bus_read(ALIAS + A_CFG, d); check("R10 alias cfg", d, {24'h0, m_cfg});
    bus_read(ALIAS + A_DIR, d); check("R10 alias dir", d, {24'h0, m_dir});
    bus_read(ALIAS + A_OUT, d); check("R10 alias out", d, {24'h0, m_out});
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_write(12'h004, 32'hFFFF_FFFF);
    bus_write(12'h040, 32'hFFFF_FFFF);
    bus_write(12'h0C0, 32'hFFFF_FFFF);
    bus_write(12'h180, 32'hFFFF_0000);
    check_all("R11 hole writes");
    bus_read(12'h004, d); check("R11 read 0x004", d, 32'h0);
    bus_read(12'h0C0, d); check("R11 read 0x0C0", d, 32'h0);
  endtask

  initial begin
    #4_000_000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain();
    t_masked();
    t_mask_zero();
    t_input_sync(8'hA5);
    t_input_any_dir();
    t_ro_writes();
    t_alias_read();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule